// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Controller

This block sits between a simple single-word request port and an asynchronous DRAM whose row and column share one set of address pins. Each accepted request becomes one full access: the row half of the address is placed on the pins, RAS is pulled low, then the column half replaces it, WE (and the data bus for a write) is set up, and CAS is pulled low. For a read, OE is asserted while CAS is low and the returned word is captured a fixed number of clocks after CAS falls. Every interval is a parameter counted in system clocks.

A free-running interval timer requests refresh. Refresh uses the CAS-before-RAS order: CAS drops first, then RAS pulses while CAS stays low. A pending refresh wins over a new host request in the idle state, but an access already under way always runs to completion. Every access and refresh ends in a precharge state with both strobes high.

States: `ST_IDLE` (waiting; goes to `ST_REF_CAS` if refresh is pending, otherwise to `ST_ROW_SETUP` on an accepted request), `ST_ROW_SETUP` (row on pins, strobes high) to `ST_ROW_ACT` (RAS low, one cycle of row hold) to `ST_COL_SETUP` (column, WE and write data set up) to `ST_COL_ACT` (CAS low, read capture) to `ST_PRECHARGE`; `ST_REF_CAS` (CAS low alone) to `ST_REF_RAS` (both low) to `ST_PRECHARGE`; `ST_PRECHARGE` returns to `ST_IDLE`.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After reset all four strobes are high (inactive), the data bus is not driven, `rsp_valid` is low and `req_ready` is high.
- R2: Before RAS falls for an access, the row address is held on `dram_addr` with all strobes high for at least `T_RSU` clocks.
- R3: RAS stays low for at least `T_RAS` clocks in both accesses and refreshes.
- R4: Before CAS falls for an access, the column address is held on `dram_addr` for at least `T_CSU` clocks with RAS low, and WE already has its final level (high for read, low for write).
- R5: During a write, WE is low, the data bus is driven with the request's write data before and while CAS is low, and OE stays high.
- R6: During a read, OE is low while CAS is low; the word on `dram_dq_in` is captured exactly `T_RDLAT` clocks after CAS falls and presented on `rsp_rdata` with a one-cycle `rsp_valid` pulse.
- R7: CAS stays low for at least `T_CAS` clocks in an access.
- R8: An access or refresh ends with RAS and CAS returning high together, and both stay high for at least `T_PRE` clocks before either falls again.
- R9: A refresh drops CAS at least `T_CSU` clocks before RAS, with WE high, and keeps CAS low while RAS is low.
- R10: A refresh is requested every `T_REFI` clocks; a pending refresh is started from idle before any host request and never interrupts an access.
- R11: The upper `ROW_W` bits of `req_addr` form the row and the lower `ROW_W` bits form the column.
- R12: A request is accepted only in a cycle with `req_valid` and `req_ready` high; `req_ready` is low from the cycle after acceptance until the access and its precharge end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ROW_W | Word address, row in upper half |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DW | Captured read word |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DW | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable for the data bus driver |
| dram_dq_in | input | DW | Data returned by the DRAM |

## Verification
The assertions assume the timing parameters satisfy `T_RSU`, `T_CSU`, `T_PRE` of at least 1 and `1 <= T_RDLAT <= T_CAS`, and that the host holds `req_valid` and its fields steady until acceptance. The bench keeps to this by raising `req_valid` only between clock edges, dropping it right after the accepting edge, and changing address and data only while it is low. A behavioural memory in the bench latches row and column on the strobe edges, returns garbage until CAS has been low long enough, and so exposes an early capture.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_SETUP,
        ST_ROW_ACT,
        ST_COL_SETUP,
        ST_COL_ACT,
        ST_REF_CAS,
        ST_REF_RAS,
        ST_PRECHARGE
    } dram_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int T_REFI = 256,
    localparam int CW = $clog2(T_REFI + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    logic [CW-1:0] tick_cnt;
    logic          tick;

    assign tick = (tick_cnt == CW'(T_REFI - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            pend     <= 1'b0;
        end else begin
            tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
            if (tick)
                pend <= 1'b1;
            else if (ack)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
    parameter int ROW_W = 10,
    localparam int AW = 2 * ROW_W
) (
    input  logic [AW-1:0]    word_addr,
    input  logic             sel_col,
    output logic [ROW_W-1:0] pin_addr
);
    logic [ROW_W-1:0] row_part;
    logic [ROW_W-1:0] col_part;

    assign row_part = word_addr[AW-1:ROW_W];
    assign col_part = word_addr[ROW_W-1:0];
    assign pin_addr = sel_col ? col_part : row_part;
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W   = 10,
    parameter int DW      = 16,
    parameter int T_RSU   = 2,
    parameter int T_RAS   = 6,
    parameter int T_CSU   = 2,
    parameter int T_CAS   = 3,
    parameter int T_RDLAT = 2,
    parameter int T_PRE   = 3,
    parameter int T_REFI  = 256,
    localparam int AW      = 2 * ROW_W,
    localparam int CAS_LEN = imax(T_CAS, T_RAS - 1 - T_CSU),
    localparam int REF_LEN = imax(T_RAS, T_CAS),
    localparam int LMAX    = imax(imax(T_RSU, T_CSU), imax(imax(CAS_LEN, REF_LEN), T_PRE)),
    localparam int CW      = $clog2(LMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic [ROW_W-1:0] dram_addr,
    output logic             dram_ras_n,
    output logic             dram_cas_n,
    output logic             dram_we_n,
    output logic             dram_oe_n,
    output logic [DW-1:0]    dram_dq_out,
    output logic             dram_dq_oe,
    input  logic [DW-1:0]    dram_dq_in
);
    dram_state_e   st, nxt;
    logic [CW-1:0] cnt;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic          lat_wr;
    logic          ref_pend;
    logic          ref_ack;
    logic          accept;
    logic          sel_col;
    logic          capture;

    function automatic logic [CW-1:0] dur(input dram_state_e s);
        unique case (s)
            ST_ROW_SETUP: return CW'(T_RSU - 1);
            ST_COL_SETUP: return CW'(T_CSU - 1);
            ST_COL_ACT:   return CW'(CAS_LEN - 1);
            ST_REF_CAS:   return CW'(T_CSU - 1);
            ST_REF_RAS:   return CW'(REF_LEN - 1);
            ST_PRECHARGE: return CW'(T_PRE - 1);
            default:      return '0;
        endcase
    endfunction

    assign req_ready = (st == ST_IDLE) && !ref_pend;
    assign accept    = req_ready && req_valid;
    assign ref_ack   = (st == ST_IDLE) && ref_pend;
    assign capture   = (st == ST_COL_ACT) && !lat_wr && (cnt == CW'(CAS_LEN - T_RDLAT));

    dram_refresh_timer #(.T_REFI(T_REFI)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    dram_addr_split #(.ROW_W(ROW_W)) u_split (
        .word_addr(lat_addr),
        .sel_col  (sel_col),
        .pin_addr (dram_addr)
    );

    // next-state decision
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (ref_pend)       nxt = ST_REF_CAS;
                else if (req_valid) nxt = ST_ROW_SETUP;
            end
            ST_ROW_SETUP: if (cnt == '0) nxt = ST_ROW_ACT;
            ST_ROW_ACT:                  nxt = ST_COL_SETUP;
            ST_COL_SETUP: if (cnt == '0) nxt = ST_COL_ACT;
            ST_COL_ACT:   if (cnt == '0) nxt = ST_PRECHARGE;
            ST_REF_CAS:   if (cnt == '0) nxt = ST_REF_RAS;
            ST_REF_RAS:   if (cnt == '0) nxt = ST_PRECHARGE;
            ST_PRECHARGE: if (cnt == '0) nxt = ST_IDLE;
            default:                     nxt = ST_IDLE;
        endcase
    end

    // state register, interval counter, request latch, read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_wr    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            st <= nxt;
            if (nxt != st)
                cnt <= dur(nxt);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
            if (accept) begin
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
                lat_wr    <= req_write;
            end
            rsp_valid <= capture;
            if (capture)
                rsp_rdata <= dram_dq_in;
        end
    end

    // strobe and bus outputs decoded from the state
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        dram_oe_n  = 1'b1;
        dram_dq_oe = 1'b0;
        sel_col    = 1'b0;
        unique case (st)
            ST_ROW_ACT: dram_ras_n = 1'b0;
            ST_COL_SETUP: begin
                dram_ras_n = 1'b0;
                sel_col    = 1'b1;
                dram_we_n  = !lat_wr;
                dram_dq_oe = lat_wr;
            end
            ST_COL_ACT: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                sel_col    = 1'b1;
                dram_we_n  = !lat_wr;
                dram_dq_oe = lat_wr;
                dram_oe_n  = lat_wr;
            end
            ST_REF_CAS: dram_cas_n = 1'b0;
            ST_REF_RAS: begin
                dram_cas_n = 1'b0;
                dram_ras_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign dram_dq_out = lat_wdata;

endmodule

// File: rtl/dram_strobe_chk.sv
module dram_strobe_chk
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int T_RAS = 6,
    parameter int T_CAS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [ROW_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_oe_n,
    input logic             dram_dq_oe,
    input dram_state_e      st,
    input logic             ref_pend
);
    logic [15:0] ras_lo;
    logic [15:0] cas_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo <= '0;
            cas_lo <= '0;
        end else begin
            ras_lo <= dram_ras_n ? '0 : ras_lo + 1'b1;
            cas_lo <= dram_cas_n ? '0 : cas_lo + 1'b1;
        end
    end

    assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (ras_lo >= 16'(T_RAS)));

    assert_col_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> ($stable(dram_addr) && $stable(dram_we_n)));

    assert_write_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && !dram_we_n) |-> (dram_dq_oe && dram_oe_n));

    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !$past(dram_oe_n));

    assert_cas_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dram_cas_n) && $past(!dram_we_n || !dram_oe_n)) |-> (cas_lo >= 16'(T_CAS)));

    assert_both_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> dram_cas_n);

    assert_cas_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> (!$past(dram_cas_n) && dram_we_n));

    assert_ref_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && ref_pend) |=> (!dram_cas_n && dram_ras_n));

    assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind dram_strobe_ctrl dram_strobe_chk #(
    .ROW_W(ROW_W),
    .T_RAS(T_RAS),
    .T_CAS(T_CAS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .dram_addr (dram_addr),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_we_n (dram_we_n),
    .dram_oe_n (dram_oe_n),
    .dram_dq_oe(dram_dq_oe),
    .st        (st),
    .ref_pend  (ref_pend)
);

// File: tb/sim_dram_strobe_ctrl.sv
module sim_dram_strobe_ctrl;
    localparam int ROW_W   = 4;
    localparam int AW      = 2 * ROW_W;
    localparam int DW      = 16;
    localparam int T_RSU   = 2;
    localparam int T_RAS   = 6;
    localparam int T_CSU   = 2;
    localparam int T_CAS   = 3;
    localparam int T_RDLAT = 2;
    localparam int T_PRE   = 3;
    localparam int T_REFI  = 150;
    localparam int NWORDS  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [ROW_W-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [DW-1:0] dram_dq_out, dram_dq_in;

    int total = 0, bad = 0, cyc = 0, ref_cnt = 0;

    always #5 clk = ~clk;

    dram_strobe_ctrl #(
        .ROW_W(ROW_W), .DW(DW), .T_RSU(T_RSU), .T_RAS(T_RAS), .T_CSU(T_CSU),
        .T_CAS(T_CAS), .T_RDLAT(T_RDLAT), .T_PRE(T_PRE), .T_REFI(T_REFI)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    function automatic logic [ROW_W-1:0] row_of(input logic [AW-1:0] a);
        return a[AW-1:ROW_W];
    endfunction
    function automatic logic [ROW_W-1:0] col_of(input logic [AW-1:0] a);
        return a[ROW_W-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // memory model and shadow expectation
    logic [DW-1:0] mem [NWORDS];
    logic [DW-1:0] expm [NWORDS];
    logic [ROW_W-1:0] row_l = '0, col_l = '0;
    logic [AW-1:0] cur_addr = '0;
    logic [DW-1:0] cur_wdata = '0;
    logic cur_write = 1'b0;
    logic pr_ras = 1'b1, pr_cas = 1'b1;
    logic [ROW_W-1:0] pr_addr = '0;
    int stab = 0, cas_lo = 0, ras_lo = 0, hi_cnt = 0;

    assign dram_dq_in = (!dram_oe_n && !dram_cas_n && cas_lo >= T_RDLAT) ?
                        mem[{row_l, col_l}] : ~mem[{row_l, col_l}];

    always @(posedge clk) if (rst_n) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pr_ras && !dram_ras_n && dram_cas_n) begin
                check(stab >= T_RSU && dram_addr == pr_addr, "R2", stab, T_RSU);
                check(dram_addr == row_of(cur_addr), "R11", dram_addr, row_of(cur_addr));
                row_l = dram_addr;
            end
            if (pr_ras && !dram_ras_n && !dram_cas_n) begin
                ref_cnt++;
                check(cas_lo >= T_CSU && dram_we_n, "R9", cas_lo, T_CSU);
            end
            if (pr_cas && !dram_cas_n && !dram_ras_n) begin
                check(stab >= T_CSU && dram_addr == pr_addr, "R4", stab, T_CSU);
                check(dram_addr == col_of(cur_addr), "R11", dram_addr, col_of(cur_addr));
                check(dram_we_n == !cur_write, "R4", dram_we_n, !cur_write);
                col_l = dram_addr;
                if (!dram_we_n) begin
                    check(dram_dq_oe && dram_oe_n && dram_dq_out == cur_wdata, "R5",
                          dram_dq_out, cur_wdata);
                    mem[{row_l, dram_addr}] = dram_dq_out;
                end
            end
            if (pr_ras && pr_cas && (!dram_ras_n || !dram_cas_n))
                check(hi_cnt >= T_PRE, "R8", hi_cnt, T_PRE);
            if (!pr_cas && dram_cas_n && !pr_ras)
                check(cas_lo >= T_CAS, "R7", cas_lo, T_CAS);
            if (!pr_ras && dram_ras_n) begin
                check(ras_lo >= T_RAS, "R3", ras_lo, T_RAS);
                check(dram_cas_n, "R8", dram_cas_n, 1);
            end
        end
        stab   = (dram_addr == pr_addr) ? stab + 1 : 1;
        cas_lo = dram_cas_n ? 0 : cas_lo + 1;
        ras_lo = dram_ras_n ? 0 : ras_lo + 1;
        hi_cnt = (dram_ras_n && dram_cas_n) ? hi_cnt + 1 : 0;
        pr_ras = dram_ras_n;
        pr_cas = dram_cas_n;
        pr_addr = dram_addr;
    end

    task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cur_addr = a; cur_wdata = d; cur_write = wr;
        req_addr = a; req_wdata = d; req_write = wr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R12", req_ready, 0);
        if (wr) begin
            expm[a] = d;
            for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
        end else begin
            for (int i = 0; i < 100 && !rsp_valid; i++) @(negedge clk);
            check(rsp_valid && rsp_rdata == expm[a], "R6", rsp_rdata, expm[a]);
            @(negedge clk);
            check(!rsp_valid, "R6", rsp_valid, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < NWORDS; i++) begin
            mem[i]  = DW'(i * 37 + 5);
            expm[i] = DW'(i * 37 + 5);
        end
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !rsp_valid,
              "R1", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !dram_dq_oe, "R1", req_ready, 1);
        // directed corners
        issue(1'b0, 8'h00, '0);
        issue(1'b1, 8'h00, 16'hFFFF);
        issue(1'b0, 8'h00, '0);
        issue(1'b1, 8'hFF, 16'h0000);
        issue(1'b0, 8'hFF, '0);
        issue(1'b1, 8'h5A, 16'hA5C3);
        issue(1'b1, 8'h77, 16'h1234);
        issue(1'b0, 8'h5A, '0);
        issue(1'b0, 8'h77, '0);
        // idle window: refresh still runs
        repeat (3 * T_REFI) @(negedge clk);
        // random traffic
        for (int n = 0; n < 120; n++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            if ($urandom % 2) issue(1'b1, a, DW'($urandom));
            else              issue(1'b0, a, '0);
        end
        check(ref_cnt >= cyc / T_REFI - 1 && ref_cnt <= cyc / T_REFI, "R10", ref_cnt, cyc / T_REFI);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        total++; bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule